// File: doc/BRIEF.md
# Circuit-Switched Owner Path Table

This block sits beside each tile's network interface in a 16-tile mesh. It keeps a small table of circuit-switched paths to other tiles. Each entry links a memory region tag to the tile that last supplied data for that region. Every outgoing coherence miss is looked up in the table. On a hit, the request is marked for the direct path to the predicted owner, and a copy still goes to the home directory. On a miss, the request takes the ordinary directory route.

When the owner's reply to a directory-routed miss comes back, it is offered to the table as an install. A new path is opened with a setup pulse. If both entries are live, the least recently used path is closed first with a teardown pulse. A nack reports that a path request lost a race with an upgrade. It drops the entry for that region, so later requests go back through the directory.

All three inputs can arrive in the same cycle. Within that cycle they take effect in a fixed order: the install first, then the nack, then the lookup.

Top module: `cpath_ctrl`

## Requirements
- R1: After reset the table is empty: no route, teardown or setup output is active, and the first request of any tag is routed to the directory.
- R2: A request whose tag is not in the table gives, one cycle later, `route_valid`=1 with `route_direct`=0 (directory route) and `route_owner`=0.
- R3: A request whose tag is in the table gives, one cycle later, `route_valid`=1 with `route_direct`=1 and `route_owner` equal to the stored owner. `route_home` always repeats the request's home node, so the home copy is sent on both routes.
- R4: An install of a new tag while an entry is free gives no teardown. It gives a one-cycle `setup_valid` pulse two cycles after the reply, carrying the reply's owner.
- R5: An install of a new tag while all entries are live gives `teardown_valid`, carrying the evicted owner, one cycle after the reply. It gives `setup_valid` one cycle after that.
- R6: The evicted entry is the least recently used one. Both a lookup hit and an install count as a use.
- R7: An install for a tag already present with the same owner gives no pulse and only refreshes recency. With a different owner, it tears down the old owner, sets up the new one, and replaces the owner in place.
- R8: A nack drops the entry matching its tag, and later requests for that tag take the directory route. A request for that tag in the same cycle as the nack also takes the directory route. A nack for an absent tag changes nothing.
- R9: A request in the same cycle as the install of its tag sees the new entry and is routed directly.
- R10: At most `WAYS` (default 2) paths are held, and a tag never occupies two entries. A third distinct install always tears one path down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Outgoing miss request present |
| req_tag | input | TAG_W | Region tag of the miss |
| req_home | input | NODE_W | Home directory tile of the miss |
| rsp_valid | input | 1 | Owner reply: install a path |
| rsp_tag | input | TAG_W | Region tag of the reply |
| rsp_owner | input | NODE_W | Tile that supplied the data |
| nack_valid | input | 1 | Path request was refused |
| nack_tag | input | TAG_W | Region tag of the refused request |
| route_valid | output | 1 | Route decision present |
| route_direct | output | 1 | 1 = direct path to owner, 0 = directory route |
| route_owner | output | NODE_W | Predicted owner (0 on directory route) |
| route_home | output | NODE_W | Home tile that receives the copy |
| teardown_valid | output | 1 | Close a path (one-cycle pulse) |
| teardown_owner | output | NODE_W | Far end of the path being closed |
| setup_valid | output | 1 | Open a path (one-cycle pulse) |
| setup_owner | output | NODE_W | Far end of the path being opened |

## Verification
The bench targets several corner cases, each with a distinct failure signature:
- **Same-cycle install and request.** A design that looked up before installing would route that request to the directory.
- **Eviction after a hit on the older entry.** A design that ignored lookups in its recency order would tear down the wrong owner.
- **Re-install of a present tag.** With the same owner it must emit no pulse; a careless design would emit a spurious setup or a duplicate entry. With a new owner it must tear down the old path, not evict the other entry.
- **Nack in the same cycle as a request for the same tag.** A design that applied the nack late would still route that request directly.

Random traffic over a handful of tags then mixes all three inputs against a timestamp-based reference model.

// File: rtl/cpath_pkg.sv
package cpath_pkg;

    localparam int NODES_DEF = 16;
    localparam int WAYS_DEF  = 2;
    localparam int TAG_W_DEF = 12;

    typedef enum logic {
        ROUTE_DIR  = 1'b0,
        ROUTE_PATH = 1'b1
    } route_e;

    function automatic int idx_width(input int ways);
        return (ways > 1) ? $clog2(ways) : 1;
    endfunction

endpackage

// File: rtl/cpath_match.sv
module cpath_match #(
    parameter  int WAYS  = 2,
    parameter  int TAG_W = 12,
    localparam int IDX_W = cpath_pkg::idx_width(WAYS)
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][TAG_W-1:0]  tags,
    input  logic [TAG_W-1:0]            key,
    output logic [WAYS-1:0]             vec,
    output logic                        hit,
    output logic [IDX_W-1:0]            idx
);
    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign vec[g] = vld[g] && (tags[g] == key);
    end

    assign hit = |vec;

    always_comb begin
        idx = '0;
        for (int j = WAYS - 1; j >= 0; j--) begin
            if (vec[j]) idx = IDX_W'(j);
        end
    end
endmodule

// File: rtl/cpath_victim.sv
module cpath_victim #(
    parameter  int WAYS  = 2,
    localparam int IDX_W = cpath_pkg::idx_width(WAYS)
) (
    input  logic [WAYS-1:0]             vld,
    input  logic [WAYS-1:0][IDX_W-1:0]  age,
    output logic [IDX_W-1:0]            idx
);
    logic [IDX_W-1:0] free_idx;
    logic [IDX_W-1:0] old_idx;
    logic             any_free;

    always_comb begin
        free_idx = '0;
        any_free = 1'b0;
        old_idx  = '0;
        for (int j = WAYS - 1; j >= 0; j--) begin
            if (!vld[j]) begin
                free_idx = IDX_W'(j);
                any_free = 1'b1;
            end
            if (age[j] == IDX_W'(WAYS - 1)) old_idx = IDX_W'(j);
        end
    end

    assign idx = any_free ? free_idx : old_idx;
endmodule

// File: rtl/cpath_store.sv
module cpath_store #(
    parameter  int WAYS   = 2,
    parameter  int TAG_W  = 12,
    parameter  int NODE_W = 4,
    localparam int IDX_W  = cpath_pkg::idx_width(WAYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ins_valid,
    input  logic [TAG_W-1:0]  ins_tag,
    input  logic [NODE_W-1:0] ins_owner,
    input  logic              nack_valid,
    input  logic [TAG_W-1:0]  nack_tag,
    input  logic              req_valid,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              lk_hit,
    output logic [NODE_W-1:0] lk_owner,
    output logic              td_req,
    output logic [NODE_W-1:0] td_owner,
    output logic              su_req
);
    typedef logic [WAYS-1:0][IDX_W-1:0]  age_vec_t;
    typedef logic [WAYS-1:0][TAG_W-1:0]  tag_vec_t;
    typedef logic [WAYS-1:0][NODE_W-1:0] own_vec_t;

    logic [WAYS-1:0] valid_q, v1, v2;
    tag_vec_t        tag_q, t1;
    own_vec_t        own_q, o1;
    age_vec_t        age_q, a1, a3;

    logic [WAYS-1:0]  ins_vec, nk_vec, lk_vec;
    logic             ins_hit, nk_hit;
    logic [IDX_W-1:0] ins_idx, nk_idx, lk_idx, vic_idx, slot;

    // Recency rank: 0 is most recent, WAYS-1 is least recent.
    function automatic age_vec_t touch(input age_vec_t a, input logic [IDX_W-1:0] w);
        age_vec_t r;
        r = a;
        for (int j = 0; j < WAYS; j++) begin
            if (a[j] < a[w]) r[j] = a[j] + 1'b1;
        end
        r[w] = '0;
        return r;
    endfunction

    cpath_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_ins_match (
        .vld(valid_q), .tags(tag_q), .key(ins_tag),
        .vec(ins_vec), .hit(ins_hit), .idx(ins_idx)
    );

    cpath_victim #(.WAYS(WAYS)) u_victim (
        .vld(valid_q), .age(age_q), .idx(vic_idx)
    );

    // Stage 1: install applied to the current table.
    always_comb begin
        v1       = valid_q;
        t1       = tag_q;
        o1       = own_q;
        a1       = age_q;
        td_req   = 1'b0;
        su_req   = 1'b0;
        slot     = ins_hit ? ins_idx : vic_idx;
        td_owner = own_q[slot];
        if (ins_valid) begin
            su_req   = !(ins_hit && (own_q[slot] == ins_owner));
            td_req   = valid_q[slot] && su_req;
            v1[slot] = 1'b1;
            t1[slot] = ins_tag;
            o1[slot] = ins_owner;
            a1       = touch(age_q, slot);
        end
    end

    cpath_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_nack_match (
        .vld(v1), .tags(t1), .key(nack_tag),
        .vec(nk_vec), .hit(nk_hit), .idx(nk_idx)
    );

    // Stage 2: nack applied after the install.
    always_comb begin
        v2 = v1;
        if (nack_valid && nk_hit) v2[nk_idx] = 1'b0;
    end

    cpath_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_req_match (
        .vld(v2), .tags(t1), .key(req_tag),
        .vec(lk_vec), .hit(lk_hit), .idx(lk_idx)
    );

    // Stage 3: lookup sees install and nack, a hit becomes most recent.
    always_comb begin
        lk_owner = o1[lk_idx];
        a3       = a1;
        if (req_valid && lk_hit) a3 = touch(a1, lk_idx);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            tag_q   <= '0;
            own_q   <= '0;
            for (int j = 0; j < WAYS; j++) age_q[j] <= IDX_W'(j);
        end else begin
            valid_q <= v2;
            tag_q   <= t1;
            own_q   <= o1;
            age_q   <= a3;
        end
    end

    // R10
    no_dup_tag_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ins_vec) && $onehot0(nk_vec) && $onehot0(lk_vec));

    // R5
    full_evict_chk: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !ins_hit && (&valid_q)) |-> td_req);
endmodule

// File: rtl/cpath_ctrl.sv
module cpath_ctrl
    import cpath_pkg::*;
#(
    parameter  int NODES  = NODES_DEF,
    parameter  int WAYS   = WAYS_DEF,
    parameter  int TAG_W  = TAG_W_DEF,
    localparam int NODE_W = $clog2(NODES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [NODE_W-1:0] req_home,
    input  logic              rsp_valid,
    input  logic [TAG_W-1:0]  rsp_tag,
    input  logic [NODE_W-1:0] rsp_owner,
    input  logic              nack_valid,
    input  logic [TAG_W-1:0]  nack_tag,
    output logic              route_valid,
    output logic              route_direct,
    output logic [NODE_W-1:0] route_owner,
    output logic [NODE_W-1:0] route_home,
    output logic              teardown_valid,
    output logic [NODE_W-1:0] teardown_owner,
    output logic              setup_valid,
    output logic [NODE_W-1:0] setup_owner
);
    logic              lk_hit, td_req, su_req;
    logic [NODE_W-1:0] lk_owner, td_own;
    route_e            kind_q;
    logic              su_pend_q;
    logic [NODE_W-1:0] su_pend_own_q;

    cpath_store #(.WAYS(WAYS), .TAG_W(TAG_W), .NODE_W(NODE_W)) u_store (
        .clk(clk), .rst(rst),
        .ins_valid(rsp_valid), .ins_tag(rsp_tag), .ins_owner(rsp_owner),
        .nack_valid(nack_valid), .nack_tag(nack_tag),
        .req_valid(req_valid), .req_tag(req_tag),
        .lk_hit(lk_hit), .lk_owner(lk_owner),
        .td_req(td_req), .td_owner(td_own), .su_req(su_req)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            route_valid    <= 1'b0;
            kind_q         <= ROUTE_DIR;
            route_owner    <= '0;
            route_home     <= '0;
            teardown_valid <= 1'b0;
            teardown_owner <= '0;
            su_pend_q      <= 1'b0;
            su_pend_own_q  <= '0;
            setup_valid    <= 1'b0;
            setup_owner    <= '0;
        end else begin
            route_valid    <= req_valid;
            kind_q         <= (req_valid && lk_hit) ? ROUTE_PATH : ROUTE_DIR;
            route_owner    <= (req_valid && lk_hit) ? lk_owner : '0;
            route_home     <= req_home;
            teardown_valid <= rsp_valid && td_req;
            teardown_owner <= td_own;
            su_pend_q      <= rsp_valid && su_req;
            su_pend_own_q  <= rsp_owner;
            setup_valid    <= su_pend_q;
            setup_owner    <= su_pend_own_q;
        end
    end

    assign route_direct = (kind_q == ROUTE_PATH);

    // R2
    route_latency_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> route_valid);

    // R3
    direct_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        route_direct |-> route_valid);

    // R5
    setup_after_teardown_chk: assert property (@(posedge clk) disable iff (rst)
        teardown_valid |=> setup_valid);

    // R4
    setup_source_chk: assert property (@(posedge clk) disable iff (rst)
        setup_valid |-> $past(rsp_valid, 2));

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk)
        $fell(rst) |-> (!route_valid && !teardown_valid && !setup_valid));
endmodule

// File: tb/cpath_ctrl_test.sv
module cpath_ctrl_test;
    localparam int TAG_W  = 12;
    localparam int NODE_W = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0, rsp_valid = 1'b0, nack_valid = 1'b0;
    logic [TAG_W-1:0]  req_tag = '0, rsp_tag = '0, nack_tag = '0;
    logic [NODE_W-1:0] req_home = '0, rsp_owner = '0;
    logic              route_valid, route_direct, teardown_valid, setup_valid;
    logic [NODE_W-1:0] route_owner, route_home, teardown_owner, setup_owner;

    int checks = 0;
    int errors = 0;

    cpath_ctrl uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_tag(req_tag), .req_home(req_home),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_owner(rsp_owner),
        .nack_valid(nack_valid), .nack_tag(nack_tag),
        .route_valid(route_valid), .route_direct(route_direct),
        .route_owner(route_owner), .route_home(route_home),
        .teardown_valid(teardown_valid), .teardown_owner(teardown_owner),
        .setup_valid(setup_valid), .setup_owner(setup_owner)
    );

    always #5 clk = ~clk;

    // Reference model: two entries with last-use timestamps.
    bit mv[2];
    int mt[2];
    int mo[2];
    int ms[2];
    int now_t = 0;
    bit pend_su = 0;
    int pend_suo = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int find(input int tag);
        for (int i = 0; i < 2; i++) if (mv[i] && mt[i] == tag) return i;
        return -1;
    endfunction

    task automatic step(input bit rv, input int rt, input int rh,
                        input bit iv, input int it, input int io,
                        input bit nv, input int nt);
        bit e_dir = 0, e_td = 0, e_su = 0;
        int e_own = 0, e_tdo = 0;
        bit prev_su = pend_su;
        int prev_suo = pend_suo;
        now_t += 2;
        if (iv) begin
            int k = find(it);
            if (k >= 0) begin
                if (mo[k] != io) begin
                    e_td = 1; e_tdo = mo[k]; e_su = 1; mo[k] = io;
                end
                ms[k] = now_t;
            end else begin
                if (!mv[0]) k = 0;
                else if (!mv[1]) k = 1;
                else begin
                    k = (ms[0] < ms[1]) ? 0 : 1;
                    e_td = 1; e_tdo = mo[k];
                end
                mv[k] = 1; mt[k] = it; mo[k] = io; ms[k] = now_t; e_su = 1;
            end
        end
        if (nv) begin
            int k = find(nt);
            if (k >= 0) mv[k] = 0;
        end
        if (rv) begin
            int k = find(rt);
            if (k >= 0) begin
                e_dir = 1; e_own = mo[k]; ms[k] = now_t + 1;
            end
        end
        pend_su = e_su;
        pend_suo = io;

        req_valid = rv; req_tag = TAG_W'(rt); req_home = NODE_W'(rh);
        rsp_valid = iv; rsp_tag = TAG_W'(it); rsp_owner = NODE_W'(io);
        nack_valid = nv; nack_tag = TAG_W'(nt);
        @(negedge clk);

        chk("R2", "route_valid", int'(route_valid), int'(rv));
        if (rv) begin
            chk(e_dir ? "R3" : "R2", "route_direct", int'(route_direct), int'(e_dir));
            chk(e_dir ? "R3" : "R2", "route_owner", int'(route_owner), e_own);
            chk("R3", "route_home", int'(route_home), rh);
        end
        chk("R5", "teardown_valid", int'(teardown_valid), int'(e_td));
        if (e_td) chk("R6", "teardown_owner", int'(teardown_owner), e_tdo);
        chk("R4", "setup_valid", int'(setup_valid), int'(prev_su));
        if (prev_su) chk("R4", "setup_owner", int'(setup_owner), prev_suo);
    endtask

    task automatic idle();
        step(0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_C0DE));
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "route_valid in reset", int'(route_valid), 0);
        chk("R1", "teardown in reset", int'(teardown_valid), 0);
        chk("R1", "setup in reset", int'(setup_valid), 0);
        rst = 1'b0;

        // R1: empty table sends to directory
        step(1, 1, 2, 0, 0, 0, 0, 0);
        chk("R1", "first request direct", int'(route_direct), 0);
        // R4: install into free entry
        step(0, 0, 0, 1, 1, 5, 0, 0);
        chk("R4", "no teardown on free install", int'(teardown_valid), 0);
        idle();
        chk("R4", "setup owner", int'(setup_owner), 5);
        // R3: hit goes direct with home copy
        step(1, 1, 3, 0, 0, 0, 0, 0);
        chk("R3", "hit direct", int'(route_direct), 1);
        chk("R3", "home copy", int'(route_home), 3);
        // R9: install and request same cycle
        step(1, 2, 4, 1, 2, 7, 0, 0);
        chk("R9", "same cycle install hit", int'(route_direct), 1);
        chk("R9", "same cycle owner", int'(route_owner), 7);
        // R6: touch tag 1 so tag 2 becomes least recent
        step(1, 1, 0, 0, 0, 0, 0, 0);
        // R10/R5/R6: third tag evicts owner 7
        step(0, 0, 0, 1, 3, 9, 0, 0);
        chk("R10", "third install tears down", int'(teardown_valid), 1);
        chk("R6", "evicted LRU owner", int'(teardown_owner), 7);
        idle();
        chk("R5", "setup follows teardown", int'(setup_valid), 1);
        // R7: same owner re-install is silent
        step(0, 0, 0, 1, 1, 5, 0, 0);
        chk("R7", "same owner no teardown", int'(teardown_valid), 0);
        idle();
        chk("R7", "same owner no setup", int'(setup_valid), 0);
        // R7: new owner replaces in place
        step(0, 0, 0, 1, 1, 11, 0, 0);
        chk("R7", "old owner torn down", int'(teardown_owner), 5);
        idle();
        chk("R7", "new owner set up", int'(setup_owner), 11);
        step(1, 3, 0, 0, 0, 0, 0, 0);
        chk("R7", "other entry kept", int'(route_direct), 1);
        // R8: nack and request same cycle
        step(1, 3, 1, 0, 0, 0, 1, 3);
        chk("R8", "nack same cycle to directory", int'(route_direct), 0);
        step(1, 3, 1, 0, 0, 0, 0, 0);
        chk("R8", "after nack to directory", int'(route_direct), 0);
        step(0, 0, 0, 0, 0, 0, 1, 9);
        step(1, 1, 1, 0, 0, 0, 0, 0);
        chk("R8", "absent nack no effect", int'(route_owner), 11);
        // R4: freed slot reused without teardown
        step(0, 0, 0, 1, 4, 6, 0, 0);
        chk("R4", "freed slot no teardown", int'(teardown_valid), 0);
        idle();

        for (int n = 0; n < 3000; n++) begin
            bit rv = ($urandom_range(0, 99) < 60);
            bit iv = ($urandom_range(0, 99) < 30);
            bit nv = ($urandom_range(0, 99) < 10);
            step(rv, $urandom_range(0, 4), $urandom_range(0, 15),
                 iv, $urandom_range(0, 4), $urandom_range(0, 15),
                 nv, $urandom_range(0, 4));
        end
        idle();
        idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule